// File: doc/BRIEF.md
# Eight-Bit Multi-Mode Tick Counter

This block is an 8-bit counter that advances on active ticks. An active tick is an input tick-enable pulse that passes a selectable power-of-two prescaler while the counter is running. Four counting modes are available: free-running, modulo, down and up/down. A terminal register input acts as the wrap or reload point in the last three modes.

Each mode has its own terminal condition. Reaching that condition sets a sticky overflow flag. When the overflow mask and a global gate are both set, reaching it also raises a one-cycle interrupt request. The current count is a port. A separate output shows when the up/down sequence is descending.

Software-style controls are plain inputs:
- a run level, which starts or halts counting;
- a one-cycle clear pulse;
- a one-cycle flag-clear pulse;
- a write strobe with data for the overflow mask.

The mask register resets to 1. Setting the mask or the gate while the flag is already set produces a fresh request.

Top module: `tmr8_core`

## Requirements
- R1: After reset: count is 0x00, the overflow flag is 0, the request is 0, `descending` is 0 and the overflow mask reads 1.
- R2: A 7-bit prescale stage counts every `tick_en` pulse from reset, whether the counter runs or not. An active tick is a `tick_en` pulse, with `run` high, in a cycle where the low `div_sel` bits of that stage are all ones. This divides by 1, 2, 4, 8, 16, 32, 64 or 128 for codes 0 to 7, and a new code applies at once.
- R3: In mode 2'b00 (free-running), each active tick adds one and wraps 0xFF to 0x00. The event is the step from 0xFE onto 0xFF.
- R4: In mode 2'b10 (modulo), an active tick moves the count from `term_val` to 0x00 and otherwise adds one. The event is any step onto `term_val` from a different value.
- R5: In mode 2'b01 (down), a rising `run` edge loads `term_val` in that cycle without stepping. Active ticks then subtract one down to 0x00, and the count holds there. The event is the step from 0x01 to 0x00.
- R6: In mode 2'b11 (up/down), the counter climbs to `term_val` and then descends to 0x00, repeatedly. `descending` is 1 from the turn at `term_val` through the following tick at 0x00. The event is the step onto 0x00 while descending. A `term_val` of 0 forces the count to 0x00, and no event occurs.
- R7: With `run` low, the count, direction and every mode action are frozen.
- R8: A `clr` pulse sets the count to 0x00 and the direction to ascending on that edge. It takes priority over loading and stepping.
- R9: The overflow flag is set on an event and stays set until an `ovf_clr` pulse. When both happen in the same cycle, the set wins.
- R10: `irq` pulses for one cycle, on the same edge as the flag sets, when an event occurs while `ovf_mask` and `irq_gate` are both 1.
- R11: When `ovf_mask & irq_gate` goes from 0 to 1 while the flag is set, `irq` pulses once, one cycle after the edge where that condition became true. `mask_wr` loads `mask_wdata` into `ovf_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Tick pulse feeding the prescaler |
| run | input | 1 | 1 counts, 0 halts |
| clr | input | 1 | Pulse: clear count |
| mode | input | 2 | 00 free, 01 down, 10 modulo, 11 up/down |
| div_sel | input | 3 | Prescale code, divide by 2^code |
| term_val | input | 8 | Terminal / reload value |
| ovf_clr | input | 1 | Pulse: clear overflow flag |
| mask_wr | input | 1 | Write strobe for the overflow mask |
| mask_wdata | input | 1 | New mask value |
| irq_gate | input | 1 | Global interrupt enable |
| count | output | 8 | Current count |
| descending | output | 1 | Up/down mode is on its falling leg |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_mask | output | 1 | Overflow mask register |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The input patterns used are:
- Dense ticks with division by 1 expose off-by-one errors at the 0xFF wrap and at the modulo and turnaround points.
- Sparse, random ticks with prescale codes changed mid-run separate a prescaler that keys off its own count from one that keys off the input pulses.
- Down mode is tried with loads of 0, 1 and a larger value, which tells a floor hold apart from an underflow wrap.
- Up/down mode runs with terminal values 1 and 4 and with a terminal lowered below the count. This distinguishes the event at zero from one at the top.
- Long random runs mix clear, flag-clear, mask writes and gate toggles. These show set-over-clear priority and whether arming produces a request, against a cycle model kept in the bench.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MD_FREE = 2'b00,
    MD_DOWN = 2'b01,
    MD_MOD  = 2'b10,
    MD_UPDN = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale #(
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic [DIVW-1:0] div_i,
  output logic            hit_o
);
  localparam int PW = (1 << DIVW) - 1;

  logic [PW-1:0] prs_q, prs_d, sel_mask;

  // R2: select mask has div_i low bits set
  always_comb begin
    sel_mask = '0;
    for (int i = 0; i < PW; i++) begin
      if (i < int'(div_i)) sel_mask[i] = 1'b1;
    end
  end

  always_comb begin
    prs_d = prs_q;
    if (tick_i) prs_d = prs_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prs_q <= '0;
    else        prs_q <= prs_d;
  end

  assign hit_o = tick_i & run_i & ((prs_q & sel_mask) == sel_mask);
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
  import tmr8_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic          run_i,
  input  logic          clr_i,
  input  tmr_mode_e     mode_i,
  input  logic [CW-1:0] term_i,
  output logic [CW-1:0] cnt_o,
  output logic          desc_o,
  output logic          evt_o
);
  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] TOP  = '1;

  logic [CW-1:0] cnt_q, cnt_d, cnt_up, cnt_dn;
  logic          dn_q, dn_d, run_q, start_load, evt;

  assign start_load = run_i & ~run_q & (mode_i == MD_DOWN);
  assign cnt_up     = cnt_q + ONE;
  assign cnt_dn     = cnt_q - ONE;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    evt   = 1'b0;
    if (clr_i) begin
      cnt_d = ZERO;
      dn_d  = 1'b0;
    end else if (start_load) begin
      cnt_d = term_i;
      dn_d  = 1'b0;
    end else if (hit_i) begin
      unique case (mode_i)
        MD_FREE: begin
          dn_d  = 1'b0;
          cnt_d = cnt_up;
          evt   = (cnt_q == TOP - ONE);
        end
        MD_MOD: begin
          dn_d  = 1'b0;
          cnt_d = (cnt_q == term_i) ? ZERO : cnt_up;
          evt   = (cnt_q != term_i) && (cnt_up == term_i);
        end
        MD_DOWN: begin
          dn_d = 1'b0;
          if (cnt_q != ZERO) begin
            cnt_d = cnt_dn;
            evt   = (cnt_q == ONE);
          end
        end
        MD_UPDN: begin
          if (term_i == ZERO) begin
            cnt_d = ZERO;
            dn_d  = 1'b0;
          end else if (!dn_q) begin
            if (cnt_q == term_i) begin
              cnt_d = cnt_dn;
              dn_d  = 1'b1;
              evt   = (cnt_q == ONE);
            end else begin
              cnt_d = cnt_up;
            end
          end else if (cnt_q == ZERO) begin
            cnt_d = ONE;
            dn_d  = 1'b0;
          end else begin
            cnt_d = cnt_dn;
            evt   = (cnt_q == ONE);
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
      run_q <= run_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign desc_o = dn_q & (mode_i == MD_UPDN);
  assign evt_o  = evt;

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == ZERO));
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> ($stable(cnt_q) && $stable(dn_q)));
  p_down_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_DOWN && cnt_q == ZERO && !clr_i && !start_load) |=> (cnt_q == ZERO));
  p_updn_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_UPDN && cnt_q <= term_i && !clr_i && !start_load) |=> (cnt_q <= $past(term_i)));
endmodule

// File: rtl/tmr8_irq.sv
module tmr8_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic flag_clr_i,
  input  logic mask_wr_i,
  input  logic mask_d_i,
  input  logic gate_i,
  output logic flag_o,
  output logic mask_o,
  output logic irq_o
);
  logic flag_q, flag_d, mask_q, mask_d, arm, arm_q, irq_q, irq_d;

  assign arm = mask_q & gate_i;

  always_comb begin
    flag_d = flag_q;
    if (evt_i)           flag_d = 1'b1;
    else if (flag_clr_i) flag_d = 1'b0;
    mask_d = mask_wr_i ? mask_d_i : mask_q;
    irq_d  = (evt_i & arm) | (flag_q & arm & ~arm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mask_q <= 1'b1;
      arm_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
      arm_q  <= arm;
      irq_q  <= irq_d;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i) |=> flag_q);
  p_evt_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> flag_q);
  p_irq_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(arm));
  p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !$past(evt_i)) |=> !irq_q || $past(evt_i));
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int CW   = 8,
  parameter int DIVW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            run,
  input  logic            clr,
  input  logic [1:0]      mode,
  input  logic [DIVW-1:0] div_sel,
  input  logic [CW-1:0]   term_val,
  input  logic            ovf_clr,
  input  logic            mask_wr,
  input  logic            mask_wdata,
  input  logic            irq_gate,
  output logic [CW-1:0]   count,
  output logic            descending,
  output logic            ovf_flag,
  output logic            ovf_mask,
  output logic            irq
);
  logic hit, evt;

  tmr8_prescale #(.DIVW(DIVW)) u_prs (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .run_i(run),
    .div_i(div_sel), .hit_o(hit)
  );

  tmr8_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .run_i(run), .clr_i(clr),
    .mode_i(tmr_mode_e'(mode)), .term_i(term_val),
    .cnt_o(count), .desc_o(descending), .evt_o(evt)
  );

  tmr8_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .flag_clr_i(ovf_clr),
    .mask_wr_i(mask_wr), .mask_d_i(mask_wdata), .gate_i(irq_gate),
    .flag_o(ovf_flag), .mask_o(ovf_mask), .irq_o(irq)
  );
endmodule

// File: tb/sim_tmr8_core.sv
`timescale 1ns/1ps
module sim_tmr8_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 0, run = 0, clr = 0, ovf_clr = 0, mask_wr = 0, mask_wdata = 0, irq_gate = 0;
  logic [1:0] mode = 0;
  logic [2:0] div_sel = 0;
  logic [7:0] term_val = 0;
  logic [7:0] count;
  logic descending, ovf_flag, ovf_mask, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [6:0] m_prs;
  logic [7:0] m_cnt;
  logic m_dn, m_runq, m_flag, m_mask, m_armq, m_irq;

  always #10 clk = ~clk;

  tmr8_core u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_prs = 0; m_cnt = 0; m_dn = 0; m_runq = 0; m_flag = 0; m_mask = 1; m_armq = 0; m_irq = 0;
  endtask

  task automatic model_step();
    logic [6:0] msk;
    logic hit, evt, arm;
    logic [7:0] nc;
    logic nd;
    msk = 7'((8'd1 << div_sel) - 8'd1);
    hit = tick_en & run & ((m_prs & msk) == msk);
    evt = 0; nc = m_cnt; nd = m_dn;
    arm = m_mask & irq_gate;
    if (clr) begin nc = 0; nd = 0; end
    else if (run && !m_runq && mode == 2'b01) begin nc = term_val; nd = 0; end
    else if (hit) begin
      case (mode)
        2'b00: begin nd = 0; nc = m_cnt + 8'd1; evt = (m_cnt == 8'hFE); end
        2'b10: begin nd = 0; nc = (m_cnt == term_val) ? 8'd0 : m_cnt + 8'd1;
                     evt = (m_cnt != term_val) && (8'(m_cnt + 8'd1) == term_val); end
        2'b01: begin nd = 0; if (m_cnt != 0) begin nc = m_cnt - 8'd1; evt = (m_cnt == 1); end end
        default: begin
          if (term_val == 0) begin nc = 0; nd = 0; end
          else if (!m_dn) begin
            if (m_cnt == term_val) begin nc = m_cnt - 8'd1; nd = 1; evt = (m_cnt == 1); end
            else nc = m_cnt + 8'd1;
          end else if (m_cnt == 0) begin nc = 1; nd = 0; end
          else begin nc = m_cnt - 8'd1; evt = (m_cnt == 1); end
        end
      endcase
    end
    m_irq = (evt & arm) | (m_flag & arm & ~m_armq);
    if (evt) m_flag = 1; else if (ovf_clr) m_flag = 0;
    if (mask_wr) m_mask = mask_wdata;
    m_armq = arm;
    if (tick_en) m_prs = m_prs + 7'd1;
    m_runq = run;
    m_cnt = nc; m_dn = nd;
  endtask

  // one clock: model after the edge, compare at the falling edge, drop pulses
  task automatic cyc(input string tag);
    @(posedge clk); #1;
    model_step();
    @(negedge clk);
    chk(count == m_cnt, tag, count, m_cnt);
    chk(descending == (m_dn && mode == 2'b11), "R6 desc", descending, m_dn && mode == 2'b11);
    chk(ovf_flag == m_flag, "R9 flag", ovf_flag, m_flag);
    chk(irq == m_irq, "R10/R11 irq", irq, m_irq);
    chk(ovf_mask == m_mask, "R11 mask", ovf_mask, m_mask);
    clr = 0; ovf_clr = 0; mask_wr = 0;
  endtask

  task automatic cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'b00: return "R3 free";
      2'b01: return "R5 down";
      2'b10: return "R4 modulo";
      default: return "R6 updown";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(count == 0, "R1 count", count, 0);
    chk(ovf_flag == 0, "R1 flag", ovf_flag, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(ovf_mask == 1, "R1 mask", ovf_mask, 1);
    chk(descending == 0, "R1 desc", descending, 0);
    rst_n = 1;

    // R3 free-running across the wrap, division by 1
    irq_gate = 1; tick_en = 1; run = 1; mode = 2'b00;
    cycles(300, "R3 free");
    chk(ovf_flag == 1, "R3 flag after wrap", ovf_flag, 1);

    // R7 halt
    run = 0; cycles(12, "R7 halt");
    run = 1;

    // R2 prescaler with sparse ticks and code changes
    for (int k = 0; k < 8; k++) begin
      div_sel = 3'(k);
      for (int i = 0; i < 150; i++) begin tick_en = ($urandom % 3) != 0; cyc("R2 prescale"); end
    end
    div_sel = 0; tick_en = 1;

    // R8 clear, R9 flag clear
    clr = 1; cyc("R8 clear");
    chk(count == 0, "R8 clear count", count, 0);
    ovf_clr = 1; cyc("R9 flag clear");
    chk(ovf_flag == 0, "R9 flag cleared", ovf_flag, 0);

    // R4 modulo with terminal 5 and 0
    mode = 2'b10; term_val = 5; clr = 1; cyc("R4 modulo");
    cycles(30, "R4 modulo");
    term_val = 0; cycles(8, "R4 modulo");

    // R5 down: loads of 7, 1, 0
    mode = 2'b01;
    foreach (term_val[b]) ;
    for (int k = 0; k < 3; k++) begin
      term_val = (k == 0) ? 8'd7 : (k == 1) ? 8'd1 : 8'd0;
      run = 0; cyc("R5 down");
      run = 1; cycles(14, "R5 down");
    end

    // R6 up/down with terminal 4 and 1, then lowered terminal
    mode = 2'b11; clr = 1; term_val = 4; cyc("R6 updown");
    cycles(30, "R6 updown");
    term_val = 1; cycles(10, "R6 updown");
    term_val = 9; cycles(6, "R6 updown");
    term_val = 3; cycles(20, "R6 updown");

    // R11 arming with flag set
    irq_gate = 0; mask_wr = 1; mask_wdata = 0; cyc("R11 arm");
    cycles(20, "R11 arm");
    irq_gate = 1; cyc("R11 arm");
    mask_wr = 1; mask_wdata = 1; cyc("R11 arm");
    cyc("R11 arm");
    irq_gate = 0; cyc("R11 arm"); irq_gate = 1; cycles(3, "R11 arm");

    // random mix
    for (int s = 0; s < 60; s++) begin
      mode = 2'($urandom);
      div_sel = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 2);
      term_val = ($urandom % 4 == 0) ? 8'($urandom % 3) : 8'($urandom);
      for (int i = 0; i < 60; i++) begin
        tick_en    = ($urandom % 4) != 0;
        run        = ($urandom % 16) != 0;
        clr        = ($urandom % 97) == 0;
        ovf_clr    = ($urandom % 13) == 0;
        mask_wr    = ($urandom % 29) == 0;
        mask_wdata = 1'($urandom);
        if ($urandom % 23 == 0) irq_gate = ~irq_gate;
        cyc(mode_tag(mode));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule